// File: doc/BRIEF.md
# Multiplexed Six-Digit Display Scanner

This block drives a six-digit multiplexed display. It takes six digits of already-latched BCD data and shows them one at a time. For the digit in turn it drives a strobe, the shared BCD bus and the shared seven-segment bus. A divide-by-six Johnson sequence picks the digit, starting at the most significant digit (MSD) and moving down to the least significant digit (LSD). A prescaler on the system clock advances the sequence once per scan period. The first part of every scan period is a blanking gap, during which no strobe and no segment is lit.

A low level on the `set_n` input forces the scan to the MSD. The MSD strobe is lit, the segments are dark, and the BCD bus keeps showing the MSD code. When `set_n` goes high again, scanning resumes from the MSD.

Optional leading-zero suppression darkens the segments of zero digits at the high end of the number. It does not touch strobes or BCD data. The `lzb_off` input turns this suppression off.

Top module: `disp_scan6`

## Requirements
- R1: While `rst_n` is low, every strobe and every segment is off and the BCD bus carries the MSD code (digit index 5).
- R2: Digits are selected in the order index 5, 4, 3, 2, 1, 0 and then back to 5. The selection moves once every `SCAN_DIV` clocks. Strobe bit i belongs to digit index i, and at most one strobe is ever high.
- R3: For the first `BLANK_CYC` clocks of each scan period, all strobes and all segments are low. The default `BLANK_CYC` is `SCAN_DIV/8`.
- R4: `bcd_out` always equals the 4-bit code of the selected digit, taken from `digits_bcd[4*i+3:4*i]`. During normal scanning it changes only on the clock that starts a blanking gap.
- R5: From the first clock edge at which `set_n` is sampled low, and for as long as it stays low, only strobe bit 5 is high, the segments are all low, and `bcd_out` carries the MSD code.
- R6: After `set_n` goes high, the MSD strobe stays lit for `SCAN_DIV-BLANK_CYC` clocks. The scan then enters a blanking gap with digit index 4 selected.
- R7: With `lzb_off` low, zero digits from index 5 downward are darkened up to the first nonzero code. Index 0 is never suppressed. Strobes and `bcd_out` are unchanged by this.
- R8: With `lzb_off` high, no digit is suppressed. Zero digits show the zero pattern.
- R9: Segment bits map as a=bit0 through g=bit6, and a lit segment is driven high. Codes 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex). Codes 10 to 15 give all segments off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_n | input | 1 | Low forces the scan to the MSD and darkens the segments |
| lzb_off | input | 1 | High disables leading-zero suppression |
| digits_bcd | input | 24 | Six BCD codes, index 0 (LSD) in bits 3:0 |
| strobe | output | 6 | Digit strobes, active high, bit i for digit index i |
| bcd_out | output | 4 | Code of the selected digit |
| seg_out | output | 7 | Segments a..g in bits 0..6, active high |

## Verification
Several properties are checked on every cycle:
- at most one strobe is high;
- nothing is lit during a blanking gap;
- each prescaler tick moves the position one step, wrapping from the LSD to the MSD;
- the position changes only at the start of a gap;
- `set_n` held low gives the MSD strobe with dark segments;
- the LSD is never darkened when it holds a valid code.

Other behaviour shows up only in the bench's scenarios, which compare every output against an independent model over full scan cycles. This covers:
- the exact segment patterns;
- where the leading-zero run ends for various digit patterns;
- the effect of `lzb_off`;
- the dwell of the MSD after `set_n` is released.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;

  typedef logic [6:0] seg_t;

  // Segment a = bit0 ... g = bit6, lit = 1; codes above 9 give a dark digit.
  function automatic seg_t seg_decode(input logic [3:0] code);
    case (code)
      4'd0:    seg_decode = 7'h3F;
      4'd1:    seg_decode = 7'h06;
      4'd2:    seg_decode = 7'h5B;
      4'd3:    seg_decode = 7'h4F;
      4'd4:    seg_decode = 7'h66;
      4'd5:    seg_decode = 7'h6D;
      4'd6:    seg_decode = 7'h7D;
      4'd7:    seg_decode = 7'h07;
      4'd8:    seg_decode = 7'h7F;
      4'd9:    seg_decode = 7'h6F;
      default: seg_decode = 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int SCAN_DIV  = 64,
  parameter int BLANK_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_n,
  output logic tick_o,
  output logic blank_o
);
  localparam int CW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [CW-1:0] LAST  = CW'(SCAN_DIV - 1);
  localparam logic [CW-1:0] BLANK = CW'(BLANK_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!set_n)     cnt <= BLANK;   // hold just past the gap: MSD lit
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end

  assign tick_o  = set_n && (cnt == LAST);
  assign blank_o = (cnt < BLANK);
endmodule

// File: rtl/johnson_seq.sv
module johnson_seq #(
  parameter int DIGITS = 6,
  parameter int POS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_msd,
  input  logic             tick,
  output logic [POS_W-1:0] pos_o
);
  localparam int W = DIGITS / 2;

  logic [W-1:0] jst;

  function automatic logic [W-1:0] j_next(input logic [W-1:0] s);
    logic [W-1:0] n;
    n[0] = ~s[W-1];
    for (int i = 1; i < W; i++) n[i] = s[i-1];
    return n;
  endfunction

  // Sequence step: 0 at all-zero, rising while ones fill from bit 0, then falling.
  function automatic logic [POS_W-1:0] j_pos(input logic [W-1:0] s);
    int c;
    c = 0;
    for (int i = 0; i < W; i++) c += int'(s[i]);
    if (s[0])        return POS_W'(c);
    else if (c == 0) return '0;
    else             return POS_W'(2 * W - c);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         jst <= '0;
    else if (force_msd) jst <= '0;
    else if (tick)      jst <= j_next(jst);
  end

  assign pos_o = j_pos(jst);
endmodule

// File: rtl/digit_out.sv
module digit_out
  import disp_scan_pkg::*;
#(
  parameter int DIGITS = 6,
  parameter int POS_W  = 3
) (
  input  logic [DIGITS*4-1:0] digits_bcd,
  input  logic [POS_W-1:0]    pos,
  input  logic                blank,
  input  logic                set_n,
  input  logic                lzb_off,
  output logic [DIGITS-1:0]   strobe,
  output logic [3:0]          bcd_out,
  output seg_t                seg_out
);
  logic [POS_W-1:0] idx;
  logic [DIGITS:0]  lead;
  logic [DIGITS-1:0] sup;

  assign idx     = POS_W'(DIGITS - 1) - pos;
  assign bcd_out = digits_bcd[idx*4 +: 4];
  assign lead[DIGITS] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign lead[i]   = lead[i+1] && (digits_bcd[i*4 +: 4] == 4'd0);
    assign strobe[i] = !blank && (idx == POS_W'(i));
    if (i == 0) begin : g_lsd
      assign sup[i] = 1'b0;
    end else begin : g_up
      assign sup[i] = lead[i] && !lzb_off;
    end
  end

  assign seg_out = (blank || !set_n || sup[idx]) ? 7'h00 : seg_decode(bcd_out);
endmodule

// File: rtl/disp_scan6.sv
module disp_scan6 #(
  parameter int DIGITS    = 6,
  parameter int SCAN_DIV  = 64,
  parameter int BLANK_CYC = SCAN_DIV / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_n,
  input  logic                lzb_off,
  input  logic [DIGITS*4-1:0] digits_bcd,
  output logic [DIGITS-1:0]   strobe,
  output logic [3:0]          bcd_out,
  output logic [6:0]          seg_out
);
  localparam int POS_W = $clog2(DIGITS);

  logic             tick_w;
  logic             blank_w;
  logic [POS_W-1:0] pos_w;

  scan_timer #(.SCAN_DIV(SCAN_DIV), .BLANK_CYC(BLANK_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .set_n(set_n),
    .tick_o(tick_w), .blank_o(blank_w)
  );

  johnson_seq #(.DIGITS(DIGITS), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .force_msd(!set_n),
    .tick(tick_w), .pos_o(pos_w)
  );

  digit_out #(.DIGITS(DIGITS), .POS_W(POS_W)) u_out (
    .digits_bcd(digits_bcd), .pos(pos_w), .blank(blank_w),
    .set_n(set_n), .lzb_off(lzb_off),
    .strobe(strobe), .bcd_out(bcd_out), .seg_out(seg_out)
  );
endmodule

// File: rtl/disp_scan6_chk.sv
module disp_scan6_chk #(
  parameter int DIGITS = 6,
  parameter int POS_W  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                set_n,
  input logic [DIGITS*4-1:0] digits_bcd,
  input logic [DIGITS-1:0]   strobe,
  input logic [6:0]          seg_out,
  input logic                blank,
  input logic                tick,
  input logic [POS_W-1:0]    pos
);
  localparam logic [POS_W-1:0]  LASTPOS = POS_W'(DIGITS - 1);
  localparam logic [DIGITS-1:0] MSDBIT  = DIGITS'(1) << (DIGITS - 1);

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

  assert_gap_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (strobe == '0 && seg_out == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pos == (($past(pos) == LASTPOS) ? '0 : $past(pos) + POS_W'(1))));

  assert_move_in_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_n && $past(set_n) && pos != $past(pos)) |-> blank);

  assert_set_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_n && $past(!set_n)) |-> (strobe == MSDBIT && seg_out == '0));

  assert_lsd_shown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe[0] && set_n && digits_bcd[3:0] <= 4'd9) |-> (seg_out != '0));
endmodule

bind disp_scan6 disp_scan6_chk #(.DIGITS(DIGITS), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_n(set_n), .digits_bcd(digits_bcd),
  .strobe(strobe), .seg_out(seg_out), .blank(blank_w),
  .tick(tick_w), .pos(pos_w)
);

// File: tb/disp_scan6_test.sv
module disp_scan6_test;
  localparam int PERIOD = 10;
  localparam int SD = 16;
  localparam int BC = 2;
  localparam int NV = 8;

  // {digits[23:0], lzb_off, expected suppression mask[5:0]}
  localparam logic [30:0] VEC [NV] = '{
    {24'h123456, 1'b0, 6'b000000},
    {24'h000000, 1'b0, 6'b111110},
    {24'h000705, 1'b0, 6'b111000},
    {24'h000705, 1'b1, 6'b000000},
    {24'h00A009, 1'b0, 6'b110000},
    {24'h900000, 1'b0, 6'b000000},
    {24'h0B0C0D, 1'b0, 6'b100000},
    {24'h000000, 1'b1, 6'b000000}
  };

  localparam logic [6:0] PAT [10] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_n = 1'b1;
  logic lzb_off = 1'b0;
  logic [23:0] digits_bcd = 24'h654321;
  logic [5:0] strobe;
  logic [3:0] bcd_out;
  logic [6:0] seg_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  disp_scan6 #(.DIGITS(6), .SCAN_DIV(SD), .BLANK_CYC(BC)) uut (
    .clk(clk), .rst_n(rst_n), .set_n(set_n), .lzb_off(lzb_off),
    .digits_bcd(digits_bcd), .strobe(strobe), .bcd_out(bcd_out), .seg_out(seg_out)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [6:0] pat_of(input logic [3:0] c);
    return (c > 4'd9) ? 7'h00 : PAT[c];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 strobe", 32'(strobe), 32'h0);
    check("R1 seg", 32'(seg_out), 32'h0);
    check("R1 bcd", 32'(bcd_out), 32'h6);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [23:0] dg;
      logic [5:0]  mask;
      int mcnt;
      int mpos;
      dg   = VEC[v][30:7];
      mask = VEC[v][5:0];
      @(negedge clk);
      digits_bcd = dg;
      lzb_off    = VEC[v][6];
      set_n      = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R5 strobe", 32'(strobe), 32'h20);
        check("R5 seg", 32'(seg_out), 32'h0);
        check("R5 bcd", 32'(bcd_out), 32'(dg[23:20]));
      end
      set_n = 1'b1;
      mcnt = BC;
      mpos = 0;
      for (int c = 0; c < 6 * SD + 2; c++) begin
        int idx;
        logic gap;
        logic [6:0] es;
        @(posedge clk);
        if (mcnt == SD - 1) begin
          mcnt = 0;
          mpos = (mpos + 1) % 6;
        end else mcnt++;
        @(negedge clk);
        idx = 5 - mpos;
        gap = (mcnt < BC);
        es  = (gap || mask[idx]) ? 7'h00 : pat_of(dg[idx*4 +: 4]);
        if (c < SD - BC)
          check("R6 strobe", 32'(strobe), gap ? 32'h0 : 32'h20);
        else
          check("R2 strobe", 32'(strobe), gap ? 32'h0 : (32'h1 << idx));
        check("R4 bcd", 32'(bcd_out), 32'(dg[idx*4 +: 4]));
        if (gap)              check("R3 seg", 32'(seg_out), 32'(es));
        else if (mask[idx])   check("R7 seg", 32'(seg_out), 32'(es));
        else if (lzb_off)     check("R8 seg", 32'(seg_out), 32'(es));
        else                  check("R9 seg", 32'(seg_out), 32'(es));
      end
    end

    // R9: direct walk of every code on the LSD with suppression off
    lzb_off = 1'b1;
    for (int code = 0; code < 16; code++) begin
      @(negedge clk);
      digits_bcd = 24'(code);
      set_n = 1'b0;
      @(negedge clk);
      set_n = 1'b1;
      repeat (5 * SD + 1) @(negedge clk);
      check("R9 lsd strobe", 32'(strobe), 32'h1);
      check("R9 lsd seg", 32'(seg_out), 32'(pat_of(4'(code))));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule